// File: doc/BRIEF.md
# Audio Serial Port Control and Status Register File

This block is the 32-bit register file that software uses to run a stereo audio serial port. Software writes one-shot commands to turn the receiver, the transmitter and the bit-clock generator on and off. It also programs a free-form mode word that the datapath decodes. Software reads back a status word that combines live enable and ready levels with sticky error flags.

The receive and transmit datapaths send single-cycle strobes to the block when an overrun or underrun occurs, along with a 3-bit channel index. The block latches a summary flag for each error and a flag for each of the eight channels. Software can clear any sticky flag, or force it on, through two alias addresses. A mask chosen through enable and disable aliases selects which status bits drive the level interrupt.

The register bus is single-cycle. Writes take effect at the clock edge where `bus_we` is high. Read data is registered, so it appears on `bus_rdata` one cycle after the address is presented. All offsets are byte addresses, 4 bytes apart. The command, mode and status registers sit at 0x00, 0x04 and 0x08. Status clear and status set sit at 0x0C and 0x10. Interrupt enable, interrupt disable and interrupt mask sit at 0x14, 0x18 and 0x1C. The receive holding register is at 0x20, the transmit holding register at 0x24, and the version register at 0x28.

Top module: `aud_port_csr`

## Requirements
- R1: After reset, the outputs `rx_on`, `tx_on`, `clk_on` and `irq` are 0, and the mode, status and mask registers read 0.
- R2: Command register bit pairs (on, off): receiver (0, 1), clock (2, 3), transmitter (4, 5). When both bits of a pair are written as 1 in the same write, the off bit wins. A read of the command register returns 0.
- R3: The mode register at 0x04 is fully read/write, and its value appears on `mode_q`.
- R4: Status bit 0 shows `rx_on` and bit 4 shows `tx_on`. Status bit 1 follows the `rx_ready` input and bit 5 follows the `tx_ready` input.
- R5: An `rx_ovr_evt` strobe sets status bit 2 and bit 8+`rx_ovr_ch`. A `tx_und_evt` strobe sets status bit 6 and bit 20+`tx_und_ch`. These flags stay set until they are cleared.
- R6: Writing 1 to a bit at 0x0C clears that sticky bit. Writing 0 leaves it unchanged.
- R7: Writing 1 to a bit at 0x10 sets that sticky bit. Bits that are not sticky are unaffected.
- R8: A write at 0x14 sets mask bits and a write at 0x18 clears them. Only bits 1, 2, 5 and 6 exist in the mask. The mask at 0x1C is read-only, and writes to it are ignored.
- R9: `irq` is high exactly when the status word ANDed with the mask is non-zero.
- R10: Command bit 7 clears all enables, all sticky flags and the mask, and it takes priority over enables written in the same word. The mode register keeps its value.
- R11: The version register at 0x28 reads the `VERSION` parameter. The holding-register offsets and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_ready | input | 1 | Receive data available level |
| tx_ready | input | 1 | Transmit space available level |
| rx_ovr_evt | input | 1 | Receive overrun strobe |
| rx_ovr_ch | input | 3 | Channel of the overrun |
| tx_und_evt | input | 1 | Transmit underrun strobe |
| tx_und_ch | input | 3 | Channel of the underrun |
| rx_on | output | 1 | Receiver enabled |
| tx_on | output | 1 | Transmitter enabled |
| clk_on | output | 1 | Clock generator enabled |
| mode_q | output | 32 | Mode word |
| irq | output | 1 | Level interrupt |

## Verification
A write or event strobe changes the enables, `mode_q` and `irq` one clock edge after it is applied. The bench samples these outputs on the falling edge that follows that edge. A read returns data one edge after its address is presented. The driver therefore queues the expected word at the moment it presents the address. A registered pending flag then tells the monitor to pop and compare on the falling edge right after the capture edge. Every read is issued only after the write it depends on has completed.

// File: rtl/aud_port_csr.sv
module aud_port_csr #(
  parameter int          AW      = 6,
  parameter logic [31:0] VERSION = 32'h0000_0210
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          rx_ready,
  input  logic          tx_ready,
  input  logic          rx_ovr_evt,
  input  logic [2:0]    rx_ovr_ch,
  input  logic          tx_und_evt,
  input  logic [2:0]    tx_und_ch,
  output logic          rx_on,
  output logic          tx_on,
  output logic          clk_on,
  output logic [31:0]   mode_q,
  output logic          irq
);
  localparam logic [31:0] STICKY_BITS = 32'h0FF0_FF44;
  localparam logic [31:0] MASK_BITS   = 32'h0000_0066;

  logic        sel_cmd, sel_mode, sel_stat, sel_sclr, sel_sset;
  logic        sel_ien, sel_idis, sel_imsk, sel_ver;
  logic        wr_cmd, wr_mode, wr_sclr, wr_sset, wr_ien, wr_idis, soft_rst;
  logic [31:0] sticky, sticky_evt, imask, status;

  assign sel_cmd  = bus_addr == AW'(8'h00);
  assign sel_mode = bus_addr == AW'(8'h04);
  assign sel_stat = bus_addr == AW'(8'h08);
  assign sel_sclr = bus_addr == AW'(8'h0C);
  assign sel_sset = bus_addr == AW'(8'h10);
  assign sel_ien  = bus_addr == AW'(8'h14);
  assign sel_idis = bus_addr == AW'(8'h18);
  assign sel_imsk = bus_addr == AW'(8'h1C);
  assign sel_ver  = bus_addr == AW'(8'h28);

  assign wr_cmd   = bus_we && sel_cmd;
  assign wr_mode  = bus_we && sel_mode;
  assign wr_sclr  = bus_we && sel_sclr;
  assign wr_sset  = bus_we && sel_sset;
  assign wr_ien   = bus_we && sel_ien;
  assign wr_idis  = bus_we && sel_idis;
  assign soft_rst = wr_cmd && bus_wdata[7];

  assign sticky_evt = (rx_ovr_evt ? (32'h0000_0004 | (32'h0000_0100 << rx_ovr_ch)) : 32'h0)
                    | (tx_und_evt ? (32'h0000_0040 | (32'h0010_0000 << tx_und_ch)) : 32'h0);

  assign status = sticky | {26'h0, tx_ready, tx_on, 2'b00, rx_ready, rx_on};
  assign irq    = |(status & imask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_on  <= 1'b0;
      tx_on  <= 1'b0;
      clk_on <= 1'b0;
    end else if (soft_rst) begin
      rx_on  <= 1'b0;
      tx_on  <= 1'b0;
      clk_on <= 1'b0;
    end else if (wr_cmd) begin
      if (bus_wdata[1])      rx_on  <= 1'b0;
      else if (bus_wdata[0]) rx_on  <= 1'b1;
      if (bus_wdata[3])      clk_on <= 1'b0;
      else if (bus_wdata[2]) clk_on <= 1'b1;
      if (bus_wdata[5])      tx_on  <= 1'b0;
      else if (bus_wdata[4]) tx_on  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (wr_mode) mode_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sticky <= '0;
    else if (soft_rst) sticky <= '0;
    else sticky <= ((sticky & ~(wr_sclr ? bus_wdata : 32'h0))
                   | (wr_sset ? bus_wdata : 32'h0) | sticky_evt) & STICKY_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        imask <= '0;
    else if (soft_rst) imask <= '0;
    else imask <= (imask | (wr_ien ? bus_wdata : 32'h0))
                  & ~(wr_idis ? bus_wdata : 32'h0) & MASK_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_rdata <= '0;
    else if (sel_mode) bus_rdata <= mode_q;
    else if (sel_stat) bus_rdata <= status;
    else if (sel_imsk) bus_rdata <= imask;
    else if (sel_ver)  bus_rdata <= VERSION;
    else               bus_rdata <= '0;
  end

  AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !bus_wdata[7] && bus_wdata[1] && bus_wdata[0]) |=> !rx_on) // R2
    else $error("receiver on despite off bit");

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(mode_q)) // R10
    else $error("mode changed without a mode write");

  AST_OVR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr_evt && !soft_rst) |=> sticky[2]) // R5
    else $error("overrun not latched");

  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sclr && bus_wdata[6] && !tx_und_evt) |=> !sticky[6]) // R6
    else $error("underrun flag not cleared");

  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (imask == 32'h0) |-> !irq) // R9
    else $error("irq without mask");

  AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!rx_on && !tx_on && !clk_on && imask == 32'h0)) // R10
    else $error("soft reset incomplete");
endmodule

// File: tb/aud_port_csr_tb.sv
module aud_port_csr_tb;
  localparam logic [31:0] VER = 32'h0000_0210;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_ready = 1'b0, tx_ready = 1'b0;
  logic        rx_ovr_evt = 1'b0, tx_und_evt = 1'b0;
  logic [2:0]  rx_ovr_ch = '0, tx_und_ch = '0;
  logic        rx_on, tx_on, clk_on, irq;
  logic [31:0] mode_q;

  int checks = 0, errors = 0;
  logic rd_req = 1'b0, rd_pend = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  aud_port_csr #(.AW(6), .VERSION(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_ready(rx_ready),
    .tx_ready(tx_ready), .rx_ovr_evt(rx_ovr_evt), .rx_ovr_ch(rx_ovr_ch),
    .tx_und_evt(tx_und_evt), .tx_und_ch(tx_und_ch), .rx_on(rx_on),
    .tx_on(tx_on), .clk_on(clk_on), .mode_q(mode_q), .irq(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; rd_req = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic ovr(input logic [2:0] ch);
    @(negedge clk);
    rx_ovr_evt = 1'b1; rx_ovr_ch = ch;
    @(negedge clk);
    rx_ovr_evt = 1'b0;
  endtask

  task automatic und(input logic [2:0] ch);
    @(negedge clk);
    tx_und_evt = 1'b1; tx_und_ch = ch;
    @(negedge clk);
    tx_und_evt = 1'b0;
  endtask

  always_ff @(posedge clk) rd_pend <= rd_req;

  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual %h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 enables", {29'h0, rx_on, tx_on, clk_on}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd(6'h04, 32'h0, "R1 mode");
    rd(6'h08, 32'h0, "R1 status");
    rd(6'h1C, 32'h0, "R1 mask");
    rd(6'h28, VER, "R11 version");
    rd(6'h20, 32'h0, "R11 rx holding");

    wr(6'h04, 32'hDEAD_BEEF);
    check("R3 mode_q", mode_q, 32'hDEAD_BEEF);
    rd(6'h04, 32'hDEAD_BEEF, "R3 mode read");

    wr(6'h00, 32'h0000_0015);
    check("R2 all on", {29'h0, rx_on, tx_on, clk_on}, 32'h7);
    rd(6'h08, 32'h11, "R4 enable status");
    rd(6'h00, 32'h0, "R2 cmd reads zero");
    wr(6'h00, 32'h0000_0003);
    check("R2 off wins", {31'h0, rx_on}, 32'h0);
    wr(6'h00, 32'h0000_000C);
    check("R2 clk off wins", {31'h0, clk_on}, 32'h0);
    rd(6'h08, 32'h10, "R4 tx only");
    rx_ready = 1'b1; tx_ready = 1'b1;
    rd(6'h08, 32'h32, "R4 ready levels");
    rx_ready = 1'b0; tx_ready = 1'b0;

    ovr(3'd3);
    rd(6'h08, 32'h0000_0814, "R5 overrun ch3");
    und(3'd7);
    repeat (5) @(negedge clk);
    rd(6'h08, 32'h0800_0854, "R5 underrun ch7 sticky");

    wr(6'h0C, 32'h0000_0800);
    rd(6'h08, 32'h0800_0054, "R6 clear ch3");
    wr(6'h0C, 32'h0);
    rd(6'h08, 32'h0800_0054, "R6 zero no effect");
    wr(6'h10, 32'h4000_0100);
    rd(6'h08, 32'h0800_0154, "R7 set ch0");

    check("R9 no mask", {31'h0, irq}, 32'h0);
    wr(6'h14, 32'hFFFF_FFFF);
    rd(6'h1C, 32'h66, "R8 enable mask");
    check("R9 irq on", {31'h0, irq}, 32'h1);
    wr(6'h1C, 32'h0);
    rd(6'h1C, 32'h66, "R8 mask read only");
    wr(6'h18, 32'h44);
    rd(6'h1C, 32'h22, "R8 disable");
    check("R9 irq masked off", {31'h0, irq}, 32'h0);
    rx_ready = 1'b1;
    @(negedge clk);
    check("R9 ready irq", {31'h0, irq}, 32'h1);
    rx_ready = 1'b0;

    wr(6'h14, 32'h4);
    wr(6'h00, 32'h0000_0095);
    check("R10 enables cleared", {29'h0, rx_on, tx_on, clk_on}, 32'h0);
    check("R10 mode kept", mode_q, 32'hDEAD_BEEF);
    rd(6'h08, 32'h0, "R10 status cleared");
    rd(6'h1C, 32'h0, "R10 mask cleared");
    rd(6'h24, 32'h0, "R11 tx holding");
    rd(6'h2C, 32'h0, "R11 unmapped");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule